// File: doc/BRIEF.md
# Discrete-Input Threshold Sensor SPI Register Slave

This block is the serial register front end of a 32-channel discrete-input threshold sensor. A host talks to it over SPI mode 0. The serial clock is sampled by the system clock and is assumed to be synchronous to it. Each chip-select frame opens with a command byte. Bit 7 of that byte chooses the direction and bits 6:0 name a register. The bytes after it carry the data, most significant byte first. The analog comparators sit outside the block. Their 32 decided states enter on a parallel port and are registered every clock.

The register set holds the following:
- A control byte with a test-mode enable and a soft reset.
- A sensing-mode byte with one bit per bank of eight channels.
- A test pattern byte.
- Two 16-bit threshold words. Each word holds a hysteresis byte above a center byte.
- The input states, readable through four byte-wide windows and through one 32-bit window.

Writing an odd hysteresis locks the device. While it is locked, the input-state windows read as zero. Only a soft reset or a hard reset clears the lock.

Top module: `disc_sense_spi`

## Requirements
- R1: Every frame starts with a fresh command byte once `cs_n` goes low. Bit 7 = 1 marks a read and bit 7 = 0 marks a write. Bits 6:0 are the register address. Raising `cs_n` abandons any partial frame.
- R2: `mosi` is sampled on rising `sclk` edges, MSB first. `miso` changes only after falling `sclk` edges. `miso` is 0 while `cs_n` is high and throughout the command byte.
- R3: After `rst` is asserted, every register reads 0x00 or 0x0000 and the device is unlocked.
- R4: A read of address 0x78 returns the 32 input states in four bytes, bits 31:24 first. The states are captured when the command byte completes.
- R5: Addresses 0x10, 0x12, 0x14 and 0x16 each return one byte of the input states: bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R6: The control register sits at 0x02 and reads back bits 1:0, with bits 7:2 reading 0. Bit 0 enables test mode. In test mode every bank of the input states is replaced by the test byte, which is read and written at 0x1E.
- R7: The sensing-mode register sits at 0x04. Bit n selects the mode of bank n (0 = ground-open, 1 = supply-open). Bits 7:4 read 0.
- R8: The threshold words sit at 0x3A (ground-open) and 0x3C (supply-open). Each takes the hysteresis byte first, then the center byte. A write takes effect only when both bytes arrive. A one-byte write leaves the word unchanged.
- R9: Writing a threshold word whose hysteresis byte has bit 0 = 1 stores the word and sets the lock. While locked, reads at 0x10 to 0x16 and at 0x78 return 0, and the other registers still read back.
- R10: Writing control bit 1 = 1 applies a soft reset. It clears the test enable, the sensing mode, the test byte, both threshold words and the lock. Until control bit 1 is written back to 0, writes to those registers are ignored.
- R11: Reads of unmapped addresses return 0. Bytes read past a register's width return 0. Writes to unmapped or read-only addresses, and write bytes past a register's width, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock (mode 0), synchronous to clk |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| chan_in | input | 32 | Comparator decisions of the 32 channels |

## Verification
The assertions watch `miso` on every cycle: they check that it stays quiet while the chip is deselected and that it only moves after a falling serial clock edge. They also check that the lock is set only by a committed odd-hysteresis word, that it is cleared only by a soft reset, and that a held soft reset keeps the sensing mode and the lock clear. The register map, the byte order of the wide window, the masking while locked, the test-mode substitution and the ignored bytes and addresses can only be shown by the bench, which runs whole frames against a reference model.

// File: rtl/dsi_pkg.sv
package dsi_pkg;

    localparam int BYTE_W = 8;

    localparam logic [6:0] A_CTRL    = 7'h02;
    localparam logic [6:0] A_MODE    = 7'h04;
    localparam logic [6:0] A_IN_BASE = 7'h10;
    localparam logic [6:0] A_TDATA   = 7'h1E;
    localparam logic [6:0] A_CEN_GND = 7'h3A;
    localparam logic [6:0] A_CEN_SUP = 7'h3C;
    localparam logic [6:0] A_IN_ALL  = 7'h78;

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hys;
        logic [BYTE_W-1:0] ctr;
    } cen_t;

    function automatic logic is_cen_addr(input logic [6:0] a);
        return (a == A_CEN_GND) || (a == A_CEN_SUP);
    endfunction

    function automatic logic [6:0] bank_addr(input int b);
        return A_IN_BASE + 7'(2 * b);
    endfunction

endpackage

// File: rtl/dsi_sclk_edge.sv
module dsi_sclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = !cs_n &&  sclk && !sclk_q;
    assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/dsi_shifter.sv
module dsi_shifter
    import dsi_pkg::*;
#(
    parameter int OUT_W = 32,
    parameter int CNT_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mosi,
    input  logic [OUT_W-1:0]     rd_word,
    output logic                 miso,
    output logic                 byte_done,
    output logic [CNT_W-4:0]     byte_idx,
    output logic [BYTE_W-1:0]    byte_val,
    output cmd_t                 cmd_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CMD_BITS = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  tot;
    logic [BYTE_W-2:0] in_sr;
    logic [OUT_W-1:0]  out_sr;
    logic              phase;

    assign byte_val  = {in_sr, mosi};
    assign byte_idx  = tot[CNT_W-1:3];
    assign byte_done = rise && (tot[2:0] == 3'd7) && (tot != CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            tot    <= '0;
            in_sr  <= '0;
            out_sr <= '0;
            phase  <= 1'b0;
            cmd_q  <= '0;
        end else begin
            if (rise) begin
                in_sr <= byte_val[BYTE_W-2:0];
                if (tot != CNT_MAX) tot <= tot + 1'b1;
                if (byte_done && byte_idx == '0) begin
                    cmd_q <= cmd_t'(byte_val);
                    if (byte_val[BYTE_W-1]) out_sr <= rd_word;
                end
            end
            if (fall) begin
                if (phase) out_sr <= {out_sr[OUT_W-2:0], 1'b0};
                if (tot >= CMD_BITS) phase <= 1'b1;
            end
        end
    end

    assign miso = phase & out_sr[OUT_W-1];
endmodule

// File: rtl/dsi_regs.sv
module dsi_regs
    import dsi_pkg::*;
#(
    parameter int N_CH = 32,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CH-1:0]      chan_in,
    input  logic                 wr_stb,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [6:0]           wr_addr,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic [6:0]           rd_addr,
    output logic [N_CH-1:0]      rd_word,
    output logic                 locked,
    output logic                 srst_on,
    output logic                 cen_commit,
    output logic                 cen_hys_odd,
    output logic [N_CH/8-1:0]    mode_out
);
    localparam int N_BANK = N_CH / BYTE_W;

    logic               test_en;
    logic               srst_q;
    logic [BYTE_W-1:0]  tdata_q;
    logic [N_BANK-1:0]  mode_q;
    cen_t               cen_q [2];
    logic [BYTE_W-1:0]  hys_stage;
    logic               lock_q;
    logic [N_CH-1:0]    in_q;
    logic [N_CH-1:0]    state;

    logic first_byte, cen_sel;
    assign first_byte  = wr_stb && (wr_idx == IDX_W'(1));
    assign cen_sel     = (wr_addr == A_CEN_SUP);
    assign cen_commit  = wr_stb && (wr_idx == IDX_W'(2)) && is_cen_addr(wr_addr) && !srst_q;
    assign cen_hys_odd = hys_stage[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            test_en   <= 1'b0;
            srst_q    <= 1'b0;
            tdata_q   <= '0;
            mode_q    <= '0;
            hys_stage <= '0;
            lock_q    <= 1'b0;
            in_q      <= '0;
            for (int i = 0; i < 2; i++) cen_q[i] <= '0;
        end else begin
            in_q <= chan_in;
            if (first_byte && wr_addr == A_CTRL) begin
                test_en <= wr_byte[0];
                srst_q  <= wr_byte[1];
            end else if (srst_q) begin
                test_en <= 1'b0;
            end
            if (srst_q) begin
                tdata_q   <= '0;
                mode_q    <= '0;
                hys_stage <= '0;
                lock_q    <= 1'b0;
                for (int i = 0; i < 2; i++) cen_q[i] <= '0;
            end else begin
                if (first_byte) begin
                    if (wr_addr == A_MODE)     mode_q    <= wr_byte[N_BANK-1:0];
                    if (wr_addr == A_TDATA)    tdata_q   <= wr_byte;
                    if (is_cen_addr(wr_addr))  hys_stage <= wr_byte;
                end
                if (cen_commit) begin
                    cen_q[cen_sel] <= cen_t'({hys_stage, wr_byte});
                    if (hys_stage[0]) lock_q <= 1'b1;
                end
            end
        end
    end

    assign state = test_en ? {N_BANK{tdata_q}} : in_q;

    always_comb begin
        rd_word = '0;
        case (rd_addr)
            A_CTRL:    rd_word[N_CH-1 -: BYTE_W]   = {6'b0, srst_q, test_en};
            A_MODE:    rd_word[N_CH-1 -: BYTE_W]   = BYTE_W'(mode_q);
            A_TDATA:   rd_word[N_CH-1 -: BYTE_W]   = tdata_q;
            A_CEN_GND: rd_word[N_CH-1 -: 2*BYTE_W] = cen_q[0];
            A_CEN_SUP: rd_word[N_CH-1 -: 2*BYTE_W] = cen_q[1];
            A_IN_ALL:  if (!lock_q) rd_word = state;
            default:   ;
        endcase
        for (int b = 0; b < N_BANK; b++) begin
            if (rd_addr == bank_addr(b) && !lock_q)
                rd_word[N_CH-1 -: BYTE_W] = state[BYTE_W*b +: BYTE_W];
        end
    end

    assign locked   = lock_q;
    assign srst_on  = srst_q;
    assign mode_out = mode_q;
endmodule

// File: rtl/disc_sense_spi.sv
module disc_sense_spi
    import dsi_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int CNT_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            mosi,
    output logic            miso,
    input  logic [N_CH-1:0] chan_in
);
    localparam int IDX_W  = CNT_W - 3;
    localparam int N_BANK = N_CH / BYTE_W;

    logic                sclk_rise, sclk_fall;
    logic                byte_done;
    logic [IDX_W-1:0]    byte_idx;
    logic [BYTE_W-1:0]   byte_val;
    cmd_t                cmd_q;
    logic [N_CH-1:0]     rd_word;
    logic                wr_stb;
    logic                lock_w, srst_w, cen_commit_w, cen_odd_w;
    logic [N_BANK-1:0]   mode_w;

    dsi_sclk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .cs_n (cs_n),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    dsi_shifter #(.OUT_W(N_CH), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rise      (sclk_rise),
        .fall      (sclk_fall),
        .mosi      (mosi),
        .rd_word   (rd_word),
        .miso      (miso),
        .byte_done (byte_done),
        .byte_idx  (byte_idx),
        .byte_val  (byte_val),
        .cmd_q     (cmd_q)
    );

    assign wr_stb = byte_done && (byte_idx != '0) && !cmd_q.rd;

    dsi_regs #(.N_CH(N_CH), .IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .chan_in     (chan_in),
        .wr_stb      (wr_stb),
        .wr_idx      (byte_idx),
        .wr_addr     (cmd_q.addr),
        .wr_byte     (byte_val),
        .rd_addr     (byte_val[6:0]),
        .rd_word     (rd_word),
        .locked      (lock_w),
        .srst_on     (srst_w),
        .cen_commit  (cen_commit_w),
        .cen_hys_odd (cen_odd_w),
        .mode_out    (mode_w)
    );
endmodule

// File: rtl/dsi_chk.sv
module dsi_chk #(
    parameter int N_BANK = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              miso,
    input logic              sclk_fall,
    input logic              lock_w,
    input logic              srst_w,
    input logic              cen_commit_w,
    input logic              cen_odd_w,
    input logic [N_BANK-1:0] mode_w
);
    // R2: deselected slave keeps its output low
    p_miso_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !miso);

    // R2: output bit moves only after a falling serial clock edge
    p_miso_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && (miso != $past(miso))) |-> $past(sclk_fall));

    // R9: lock only follows a committed odd hysteresis word
    p_lock_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_w) |-> $past(cen_commit_w && cen_odd_w));

    // R10: lock is released only by the soft reset
    p_lock_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_w) |-> $past(srst_w));

    // R10: a held soft reset keeps mode and lock cleared
    p_srst_clear_r10: assert property (@(posedge clk) disable iff (rst)
        srst_w |=> (mode_w == '0 && !lock_w));
endmodule

bind disc_sense_spi dsi_chk #(.N_BANK(N_CH / 8)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .miso         (miso),
    .sclk_fall    (sclk_fall),
    .lock_w       (lock_w),
    .srst_w       (srst_w),
    .cen_commit_w (cen_commit_w),
    .cen_odd_w    (cen_odd_w),
    .mode_w       (mode_w)
);

// File: tb/disc_sense_spi_bench.sv
module disc_sense_spi_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [31:0] chan_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] txb [0:7];
    logic [7:0] rxb [0:7];

    logic        m_test, m_srst, m_lock;
    logic [7:0]  m_tb;
    logic [3:0]  m_mode;
    logic [15:0] m_cen [0:1];
    logic [31:0] m_in;

    disc_sense_spi u_disc_sense_spi (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso), .chan_in(chan_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic model_clear();
        m_test = 0; m_srst = 0; m_lock = 0; m_tb = 0; m_mode = 0;
        m_cen[0] = 0; m_cen[1] = 0;
    endtask

    function automatic logic [31:0] state_now();
        return m_test ? {4{m_tb}} : m_in;
    endfunction

    function automatic logic [31:0] want_rd(input logic [6:0] a, input int n);
        logic [31:0] w = '0;
        logic [31:0] st = state_now();
        case (a)
            7'h02: w = {6'b0, m_srst, m_test, 24'h0};
            7'h04: w = {4'h0, m_mode, 24'h0};
            7'h1E: w = {m_tb, 24'h0};
            7'h3A: w = {m_cen[0], 16'h0};
            7'h3C: w = {m_cen[1], 16'h0};
            7'h78: w = m_lock ? 32'h0 : st;
            7'h10: w = m_lock ? 32'h0 : {st[7:0], 24'h0};
            7'h12: w = m_lock ? 32'h0 : {st[15:8], 24'h0};
            7'h14: w = m_lock ? 32'h0 : {st[23:16], 24'h0};
            7'h16: w = m_lock ? 32'h0 : {st[31:24], 24'h0};
            default: w = '0;
        endcase
        if (n < 4) w = w & ~(32'hFFFF_FFFF >> (8 * n));
        return w;
    endfunction

    task automatic model_wr(input logic [6:0] a, input int n, input logic [7:0] d0, d1);
        if (n >= 1 && a == 7'h02) begin
            m_test = d0[0];
            m_srst = d0[1];
            if (d0[1]) begin
                m_test = 0; m_mode = 0; m_tb = 0; m_lock = 0;
                m_cen[0] = 0; m_cen[1] = 0;
            end
        end else if (!m_srst) begin
            if (n >= 1 && a == 7'h04) m_mode = d0[3:0];
            if (n >= 1 && a == 7'h1E) m_tb = d0;
            if (n >= 2 && (a == 7'h3A || a == 7'h3C)) begin
                m_cen[a == 7'h3C] = {d0, d1};
                if (d0[0]) m_lock = 1;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    task automatic xfer(input int n);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            for (int k = 7; k >= 0; k--) begin
                mosi = txb[i][k];
                repeat (HALF) @(negedge clk);
                rxb[i][k] = miso;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_wr(input logic [6:0] a, input int n, input logic [7:0] d0, d1, d2);
        txb[0] = {1'b0, a}; txb[1] = d0; txb[2] = d1; txb[3] = d2;
        xfer(n + 1);
        model_wr(a, n, d0, d1);
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input int n);
        logic [31:0] got;
        txb[0] = {1'b1, a};
        for (int i = 1; i < 5; i++) txb[i] = 8'($urandom);
        for (int i = 0; i < 5; i++) rxb[i] = '0;
        xfer(n + 1);
        chk("R2 command byte miso low", {24'h0, rxb[0]}, 32'h0);
        got = {rxb[1], rxb[2], rxb[3], rxb[4]};
        if (n < 4) got = got & ~(32'hFFFF_FFFF >> (8 * n));
        chk(tag, got, want_rd(a, n));
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        chan_in = v;
        m_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic hard_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [6:0] alist [0:10];
        void'($urandom(32'd20251));
        m_in = '0;
        model_clear();
        alist[0] = 7'h02; alist[1] = 7'h04; alist[2] = 7'h1E; alist[3] = 7'h3A;
        alist[4] = 7'h3C; alist[5] = 7'h10; alist[6] = 7'h12; alist[7] = 7'h14;
        alist[8] = 7'h16; alist[9] = 7'h78; alist[10] = 7'h21;
        hard_reset();

        // R3 reset values
        chk("R2 idle miso low", {31'h0, miso}, 32'h0);
        rd_chk("R3 ctrl reset", 7'h02, 1);
        rd_chk("R3 mode reset", 7'h04, 1);
        rd_chk("R3 tdata reset", 7'h1E, 1);
        rd_chk("R3 gnd word reset", 7'h3A, 2);
        rd_chk("R3 sup word reset", 7'h3C, 2);

        // R4 / R5 input windows
        set_in(32'hA5C3_1E78);
        rd_chk("R4 wide read", 7'h78, 4);
        rd_chk("R4 wide msb first", 7'h78, 1);
        rd_chk("R5 bank0", 7'h10, 1);
        rd_chk("R5 bank1", 7'h12, 1);
        rd_chk("R5 bank2", 7'h14, 1);
        rd_chk("R5 bank3", 7'h16, 1);
        rd_chk("R11 byte past width", 7'h10, 2);

        // R7 mode width
        do_wr(7'h04, 1, 8'hFF, 8'h00, 8'h00);
        rd_chk("R7 mode upper bits zero", 7'h04, 1);
        do_wr(7'h04, 1, 8'h0A, 8'h00, 8'h00);
        rd_chk("R7 mode bank bits", 7'h04, 1);

        // R6 test mode
        do_wr(7'h1E, 1, 8'h5A, 8'h00, 8'h00);
        do_wr(7'h02, 1, 8'hFD, 8'h00, 8'h00);
        rd_chk("R6 ctrl readback", 7'h02, 1);
        rd_chk("R6 test pattern wide", 7'h78, 4);
        rd_chk("R6 test pattern bank", 7'h14, 1);
        do_wr(7'h02, 1, 8'h00, 8'h00, 8'h00);
        rd_chk("R6 test off inputs", 7'h78, 4);

        // R8 threshold words
        do_wr(7'h3A, 2, 8'h04, 8'h06, 8'h00);
        rd_chk("R8 gnd word", 7'h3A, 2);
        do_wr(7'h3C, 1, 8'h02, 8'h00, 8'h00);
        rd_chk("R8 partial write ignored", 7'h3C, 2);
        do_wr(7'h3C, 3, 8'h02, 8'h0A, 8'hFF);
        rd_chk("R8 sup word extra byte", 7'h3C, 2);
        rd_chk("R11 word read past width", 7'h3C, 4);

        // R11 unmapped and read-only
        rd_chk("R11 unmapped read", 7'h21, 1);
        do_wr(7'h78, 1, 8'hFF, 8'h00, 8'h00);
        do_wr(7'h10, 1, 8'h00, 8'h00, 8'h00);
        rd_chk("R11 read-only write ignored", 7'h78, 4);

        // R1 aborted frame then fresh command
        txb[0] = 8'h04; txb[1] = 8'h00;
        xfer(1);
        rd_chk("R1 fresh command after abort", 7'h04, 1);

        // R9 lock
        do_wr(7'h3A, 2, 8'h03, 8'h07, 8'h00);
        rd_chk("R9 locked wide zero", 7'h78, 4);
        rd_chk("R9 locked bank zero", 7'h14, 1);
        rd_chk("R9 locked word readable", 7'h3A, 2);
        rd_chk("R9 locked mode readable", 7'h04, 1);

        // R10 soft reset
        do_wr(7'h02, 1, 8'h02, 8'h00, 8'h00);
        rd_chk("R10 srst ctrl", 7'h02, 1);
        rd_chk("R10 srst mode cleared", 7'h04, 1);
        rd_chk("R10 srst word cleared", 7'h3A, 2);
        rd_chk("R10 srst lock cleared", 7'h78, 4);
        do_wr(7'h04, 1, 8'h05, 8'h00, 8'h00);
        rd_chk("R10 write during srst ignored", 7'h04, 1);
        do_wr(7'h02, 1, 8'h00, 8'h00, 8'h00);
        do_wr(7'h04, 1, 8'h05, 8'h00, 8'h00);
        rd_chk("R10 write after release", 7'h04, 1);

        // R10 / R3 hard reset clears lock
        do_wr(7'h3C, 2, 8'h01, 8'h09, 8'h00);
        rd_chk("R9 sup odd lock", 7'h16, 1);
        hard_reset();
        rd_chk("R3 hard reset unlock", 7'h78, 4);
        rd_chk("R3 hard reset word", 7'h3C, 2);

        // random mix
        for (int it = 0; it < 90; it++) begin
            int op = int'($urandom % 6);
            case (op)
                0: set_in($urandom);
                1: do_wr(7'h04, 1, 8'($urandom), 8'h00, 8'h00);
                2: do_wr(7'h1E, 1, 8'($urandom), 8'h00, 8'h00);
                3: begin
                    logic [7:0] c = 8'($urandom) & 8'h01;
                    if ($urandom % 5 == 0) c = c | 8'h02;
                    do_wr(7'h02, 1, c, 8'h00, 8'h00);
                end
                4: begin
                    logic [7:0] h = 8'($urandom);
                    if ($urandom % 6 != 0) h[0] = 1'b0;
                    do_wr(($urandom % 2 == 0) ? 7'h3A : 7'h3C,
                          1 + int'($urandom % 2), h, 8'($urandom), 8'h00);
                end
                default: rd_chk("R4 R5 R6 R9 random read", alist[$urandom % 11],
                                1 + int'($urandom % 4));
            endcase
        end
        rd_chk("R4 final wide", 7'h78, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule